// File: doc/BRIEF.md
# Budget-Constrained Core Mode Selector

This block chooses an operating mode for each of four processor cores so that the predicted aggregate instruction throughput is as high as possible while the predicted total power stays at or below a budget. Every mode-decision interval, a controller presents each core's present mode together with the power and instruction rate measured in that mode, plus the chip power budget, and pulses `start`. The block then predicts power and throughput for every core in every mode and checks every mode combination for the best result.

Predictions use fixed Q1.15 scaling factors. Power follows the cube of the frequency ratio between the target mode and the present mode. Throughput follows that ratio linearly and is also derated by the stall a mode change costs inside the interval. A twelve-cycle table build comes first. A search follows, which examines one combination per clock over all 81 combinations. A one-cycle `done` pulse then presents the chosen mode vector. If no combination fits the budget, the block raises `nofit` and falls back to every core in deep saving. A budget overshoot between two decisions is corrected only by the next decision.

The controller is built around the states S_IDLE, S_BUILD, S_SEARCH and S_FINISH:
- S_IDLE moves to S_BUILD when `start` is sampled; the inputs are latched at that edge.
- S_BUILD moves to S_SEARCH after its twelfth entry.
- S_SEARCH moves to S_FINISH after the 81st combination.
- S_FINISH always returns to S_IDLE.

Top module: `mode_sel_top`

## Requirements
- R1: Mode codes are 0 = full speed (frequency factor 1.0), 1 = medium saving (0.95) and 2 = deep saving (0.85). Core i's mode is carried in bits [2i+1:2i] of `cur_mode` and `mode_out`. `mode_out` never carries code 3. An input code of 3 is treated as 2.
- R2: Predicted power for core i in target mode t is (pwr_i × PF[c][t]) >> 15, where c is the core's present mode. In Q1.15, PF rows are: c=0: 32768, 28094, 20124; c=1: 38219, 32768, 23471; c=2: 53357, 45747, 32768.
- R3: Predicted throughput is (tpt_i × TF[c][t]) >> 15. TF is the frequency ratio times the transition derate: 500/507 for a change between modes 0 and 1, 500/513 between 1 and 2, and 500/520 between 0 and 2. TF rows are: c=0: 32768, 30700, 26782; c=1: 34016, 32768, 28576; c=2: 37068, 35695, 32768.
- R4: The chosen combination has the largest summed predicted throughput among all combinations whose summed predicted power is less than or equal to `budget`. A sum exactly equal to the budget fits.
- R5: Combinations are visited as a base-3 count with core 0 as the least significant digit. On equal throughput, the earlier visited combination is kept.
- R6: If no combination fits, `mode_out` becomes all 2 and `nofit` is 1. Otherwise `nofit` is 0.
- R7: `done` is high for exactly one cycle. That cycle starts at the 94th rising edge after the edge that samples `start`.
- R8: `mode_out` and `nofit` change only on the edge that raises `done`. After reset both are 0, and `busy` and `done` are 0.
- R9: `start` has no effect while `busy` is 1. The running decision finishes with its latched inputs and its normal timing.
- R10: A predicted value above 65535 saturates to 65535.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a decision; inputs are sampled on this edge |
| cur_mode | input | 8 | Present mode of each core, 2 bits per core |
| meas_pwr | input | 64 | Measured power per core, 16 bits per core |
| meas_tpt | input | 64 | Measured instruction rate per core, 16 bits per core |
| budget | input | 18 | Chip power budget, same units as power |
| busy | output | 1 | Decision in progress |
| done | output | 1 | One-cycle pulse when a result is presented |
| nofit | output | 1 | No combination met the budget |
| mode_out | output | 8 | Chosen mode per core, 2 bits per core |

## Verification
Two rules can decide the same search step: the budget test at exact equality and the tie rule on equal throughput. The bench gives four identical cores a budget that exactly matches one core at full speed and three in deep saving. This makes four candidates fit with exactly equal power and throughput. The result is judged against the first of them in base-3 order. The same setup is then repeated with the budget one unit lower, which must move the choice to the medium mode.

// File: rtl/msel_pkg.sv
package msel_pkg;
    localparam int NMODE = 3;
    localparam int QW    = 16;

    typedef enum logic [1:0] {S_IDLE, S_BUILD, S_SEARCH, S_FINISH} state_t;

    function automatic logic [1:0] clamp_mode(input logic [1:0] m);
        return (m == 2'd3) ? 2'd2 : m;
    endfunction

    // power ratio cubed, Q1.15, indexed by present and target mode
    function automatic logic [QW-1:0] pwr_factor(input logic [1:0] c, input logic [1:0] t);
        logic [QW-1:0] f;
        case ({clamp_mode(c), t})
            4'b00_00: f = 16'd32768;
            4'b00_01: f = 16'd28094;
            4'b00_10: f = 16'd20124;
            4'b01_00: f = 16'd38219;
            4'b01_01: f = 16'd32768;
            4'b01_10: f = 16'd23471;
            4'b10_00: f = 16'd53357;
            4'b10_01: f = 16'd45747;
            default:  f = 16'd32768;
        endcase
        return f;
    endfunction

    // linear ratio times stall derate, Q1.15
    function automatic logic [QW-1:0] tpt_factor(input logic [1:0] c, input logic [1:0] t);
        logic [QW-1:0] f;
        case ({clamp_mode(c), t})
            4'b00_00: f = 16'd32768;
            4'b00_01: f = 16'd30700;
            4'b00_10: f = 16'd26782;
            4'b01_00: f = 16'd34016;
            4'b01_01: f = 16'd32768;
            4'b01_10: f = 16'd28576;
            4'b10_00: f = 16'd37068;
            4'b10_01: f = 16'd35695;
            default:  f = 16'd32768;
        endcase
        return f;
    endfunction
endpackage

// File: rtl/msel_scale.sv
module msel_scale #(
    parameter int DW = 16
) (
    input  logic [DW-1:0]             meas,
    input  logic [msel_pkg::QW-1:0]   factor,
    output logic [DW-1:0]             pred
);
    localparam int PW = DW + msel_pkg::QW;
    logic [PW-1:0] prod;
    logic [DW:0]   shifted;

    always_comb begin
        prod    = PW'(meas) * PW'(factor);
        shifted = prod[DW+15:15];
        pred    = shifted[DW] ? {DW{1'b1}} : shifted[DW-1:0];
    end
endmodule

// File: rtl/msel_sum.sv
module msel_sum #(
    parameter int NCORE = 4,
    parameter int DW    = 16,
    parameter int SW    = DW + $clog2(NCORE)
) (
    input  logic [NCORE*msel_pkg::NMODE*DW-1:0] pwr_flat,
    input  logic [NCORE*msel_pkg::NMODE*DW-1:0] tpt_flat,
    input  logic [2*NCORE-1:0]                  digits,
    output logic [SW-1:0]                       psum,
    output logic [SW-1:0]                       tsum
);
    always_comb begin
        psum = '0;
        tsum = '0;
        for (int i = 0; i < NCORE; i++) begin
            for (int m = 0; m < msel_pkg::NMODE; m++) begin
                if (digits[2*i +: 2] == 2'(m)) begin
                    psum = psum + SW'(pwr_flat[(i*msel_pkg::NMODE+m)*DW +: DW]);
                    tsum = tsum + SW'(tpt_flat[(i*msel_pkg::NMODE+m)*DW +: DW]);
                end
            end
        end
    end
endmodule

// File: rtl/mode_sel_top.sv
module mode_sel_top #(
    parameter int NCORE = 4,
    parameter int DW    = 16,
    parameter int SW    = DW + $clog2(NCORE)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [2*NCORE-1:0]    cur_mode,
    input  logic [NCORE*DW-1:0]   meas_pwr,
    input  logic [NCORE*DW-1:0]   meas_tpt,
    input  logic [SW-1:0]         budget,
    output logic                  busy,
    output logic                  done,
    output logic                  nofit,
    output logic [2*NCORE-1:0]    mode_out
);
    import msel_pkg::*;

    localparam int NCOMB = NMODE ** NCORE;
    localparam int CW    = $clog2(NCOMB);
    localparam int KW    = (NCORE > 1) ? $clog2(NCORE) : 1;
    localparam int TW    = NCORE * NMODE * DW;

    state_t state_q, state_d;

    logic [2*NCORE-1:0]  cur_q;
    logic [NCORE*DW-1:0] pwr_q, tpt_q;
    logic [SW-1:0]       bud_q;
    logic [TW-1:0]       ptab_q, ttab_q;
    logic [KW-1:0]       bcore_q;
    logic [1:0]          bmode_q;
    logic [2*NCORE-1:0]  dig_q, dig_nx;
    logic [CW-1:0]       cnt_q;
    logic [SW-1:0]       best_t_q;
    logic [2*NCORE-1:0]  best_d_q;
    logic                found_q;

    logic [DW-1:0] sc_pwr_in, sc_tpt_in, sc_pwr, sc_tpt;
    logic [QW-1:0] pf, tf;
    logic [SW-1:0] psum, tsum;
    logic          build_last, search_last;

    assign build_last  = (bcore_q == KW'(NCORE-1)) && (bmode_q == 2'd2);
    assign search_last = (cnt_q == CW'(NCOMB-1));
    assign busy        = (state_q != S_IDLE);

    always_comb begin
        sc_pwr_in = pwr_q[bcore_q*DW +: DW];
        sc_tpt_in = tpt_q[bcore_q*DW +: DW];
        pf        = pwr_factor(cur_q[2*bcore_q +: 2], bmode_q);
        tf        = tpt_factor(cur_q[2*bcore_q +: 2], bmode_q);
    end

    msel_scale #(.DW(DW)) u_scale_pwr (.meas(sc_pwr_in), .factor(pf), .pred(sc_pwr));
    msel_scale #(.DW(DW)) u_scale_tpt (.meas(sc_tpt_in), .factor(tf), .pred(sc_tpt));

    msel_sum #(.NCORE(NCORE), .DW(DW), .SW(SW)) u_sum (
        .pwr_flat(ptab_q), .tpt_flat(ttab_q), .digits(dig_q),
        .psum(psum), .tsum(tsum)
    );

    // base-3 increment, core 0 least significant
    always_comb begin
        logic carry;
        carry  = 1'b1;
        dig_nx = dig_q;
        for (int i = 0; i < NCORE; i++) begin
            if (carry) begin
                if (dig_q[2*i +: 2] == 2'd2) begin
                    dig_nx[2*i +: 2] = 2'd0;
                end else begin
                    dig_nx[2*i +: 2] = dig_q[2*i +: 2] + 2'd1;
                    carry = 1'b0;
                end
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (start)       state_d = S_BUILD;
            S_BUILD:  if (build_last)  state_d = S_SEARCH;
            S_SEARCH: if (search_last) state_d = S_FINISH;
            S_FINISH:                  state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done     <= 1'b0;
            nofit    <= 1'b0;
            mode_out <= '0;
            cur_q    <= '0;
            pwr_q    <= '0;
            tpt_q    <= '0;
            bud_q    <= '0;
            ptab_q   <= '0;
            ttab_q   <= '0;
            bcore_q  <= '0;
            bmode_q  <= '0;
            dig_q    <= '0;
            cnt_q    <= '0;
            best_t_q <= '0;
            best_d_q <= '0;
            found_q  <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                S_IDLE: if (start) begin
                    cur_q   <= cur_mode;
                    pwr_q   <= meas_pwr;
                    tpt_q   <= meas_tpt;
                    bud_q   <= budget;
                    bcore_q <= '0;
                    bmode_q <= '0;
                end
                S_BUILD: begin
                    ptab_q[(bcore_q*NMODE + bmode_q)*DW +: DW] <= sc_pwr;
                    ttab_q[(bcore_q*NMODE + bmode_q)*DW +: DW] <= sc_tpt;
                    if (bmode_q == 2'd2) begin
                        bmode_q <= 2'd0;
                        bcore_q <= bcore_q + KW'(1);
                    end else begin
                        bmode_q <= bmode_q + 2'd1;
                    end
                    if (build_last) begin
                        dig_q   <= '0;
                        cnt_q   <= '0;
                        found_q <= 1'b0;
                    end
                end
                S_SEARCH: begin
                    if (psum <= bud_q && (!found_q || tsum > best_t_q)) begin
                        best_t_q <= tsum;
                        best_d_q <= dig_q;
                        found_q  <= 1'b1;
                    end
                    dig_q <= dig_nx;
                    cnt_q <= cnt_q + CW'(1);
                end
                S_FINISH: begin
                    done     <= 1'b1;
                    nofit    <= !found_q;
                    mode_out <= found_q ? best_d_q : {NCORE{2'b10}};
                end
            endcase
        end
    end
endmodule

// File: rtl/msel_chk.sv
module msel_chk #(
    parameter int NCORE = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 start,
    input logic                 busy,
    input logic                 done,
    input logic                 nofit,
    input logic [2*NCORE-1:0]   mode_out
);
    localparam logic [2*NCORE-1:0] LOW_MASK = {NCORE{2'b01}};
    localparam logic [2*NCORE-1:0] ALL_DEEP = {NCORE{2'b10}};

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_nofit_default_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && nofit) |-> (mode_out == ALL_DEEP));

    assert_mode_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_out & (mode_out >> 1) & LOW_MASK) == '0));

    assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(mode_out) && $stable(nofit)));

    assert_busy_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    assert_done_after_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));
endmodule

bind mode_sel_top msel_chk #(.NCORE(NCORE)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .done(done), .nofit(nofit), .mode_out(mode_out)
);

// File: tb/sim_mode_sel_top.sv
module sim_mode_sel_top;
    localparam int NC = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  cur_mode = '0;
    logic [63:0] meas_pwr = '0;
    logic [63:0] meas_tpt = '0;
    logic [17:0] budget = '0;
    logic        busy, done, nofit;
    logic [7:0]  mode_out;

    int n_cmp = 0;
    int n_bad = 0;
    int PF[3][3];
    int TF[3][3];

    always #5 clk = ~clk;

    mode_sel_top u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .cur_mode(cur_mode),
        .meas_pwr(meas_pwr), .meas_tpt(meas_tpt), .budget(budget),
        .busy(busy), .done(done), .nofit(nofit), .mode_out(mode_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int pred(input int meas, input int f);
        longint p;
        p = (longint'(meas) * longint'(f)) >>> 15;
        return (p > 65535) ? 65535 : int'(p);
    endfunction

    // independent exhaustive reference from R2..R6, R10
    task automatic ref_model(output logic [7:0] m, output logic nf);
        int bt;
        logic fnd;
        fnd = 1'b0; bt = 0; m = 8'hAA;
        for (int k = 0; k < 81; k++) begin
            int ps, ts, r;
            ps = 0; ts = 0; r = k;
            for (int i = 0; i < NC; i++) begin
                int c, t;
                t = r % 3; r = r / 3;
                c = int'(cur_mode[2*i +: 2]); if (c == 3) c = 2;
                ps += pred(int'(meas_pwr[16*i +: 16]), PF[c][t]);
                ts += pred(int'(meas_tpt[16*i +: 16]), TF[c][t]);
            end
            if (ps <= int'(budget) && (!fnd || ts > bt)) begin
                fnd = 1'b1; bt = ts;
                r = k;
                for (int i = 0; i < NC; i++) begin m[2*i +: 2] = 2'(r % 3); r = r / 3; end
            end
        end
        nf = !fnd;
        if (!fnd) m = 8'hAA;
    endtask

    // run one decision; returns edge count until done (95 = done after 94th edge past start edge)
    task automatic run(output int lat, input bit poke = 0);
        lat = 0;
        @(negedge clk); start = 1'b1;
        do begin
            @(negedge clk);
            lat++;
            start = 1'b0;
            if (poke && lat == 40) begin
                start = 1'b1;
                budget = 18'd0;
                meas_pwr = {4{16'd60000}};
            end
        end while (!done && lat < 300);
    endtask

    task automatic t_reset();
        check("R8 reset done", done, 0);
        check("R8 reset busy", busy, 0);
        check("R8 reset mode_out", mode_out, 0);
        check("R8 reset nofit", nofit, 0);
    endtask

    task automatic t_generic(input string tag);
        int lat;
        logic [7:0] em;
        logic en;
        ref_model(em, en);
        run(lat);
        check({tag, " R4 mode_out"}, mode_out, em);
        check({tag, " R6 nofit"}, nofit, en);
        check({tag, " R7 latency"}, lat, 95);
        @(negedge clk);
        check({tag, " R7 done one cycle"}, done, 0);
        check({tag, " R8 held"}, mode_out, em);
    endtask

    task automatic t_tie_exact();
        int lat;
        cur_mode = 8'hAA;
        meas_pwr = {4{16'd1000}};
        meas_tpt = {4{16'd1000}};
        budget   = 18'd4628;
        run(lat);
        check("R5 tie with exact budget", mode_out, 8'b00_10_10_10);
        check("R4 exact budget fits nofit", nofit, 0);
        budget   = 18'd4627;
        run(lat);
        check("R2 R3 one unit short picks medium", mode_out, 8'b01_10_10_10);
    endtask

    task automatic t_nofit();
        int lat;
        cur_mode = 8'h00;
        meas_pwr = {4{16'd1000}};
        meas_tpt = {4{16'd2000}};
        budget   = 18'd0;
        run(lat);
        check("R6 nofit flag", nofit, 1);
        check("R6 nofit all deep", mode_out, 8'hAA);
    endtask

    task automatic t_saturate();
        int lat;
        cur_mode = 8'hFF;
        meas_pwr = {16'd0, 16'd0, 16'd0, 16'd50000};
        meas_tpt = {16'd0, 16'd0, 16'd0, 16'd50000};
        budget   = 18'd65534;
        run(lat);
        check("R10 saturated power excluded", mode_out, 8'h02);
        check("R10 nofit", nofit, 0);
    endtask

    task automatic t_ignore_start();
        int lat;
        logic [7:0] em;
        logic en;
        cur_mode = 8'b01_00_10_01;
        meas_pwr = {16'd2500, 16'd1800, 16'd900, 16'd3100};
        meas_tpt = {16'd700, 16'd2600, 16'd1500, 16'd3300};
        budget   = 18'd6500;
        ref_model(em, en);
        run(lat, 1);
        check("R9 start while busy ignored mode", mode_out, em);
        check("R9 start while busy ignored nofit", nofit, en);
        check("R9 latency unchanged", lat, 95);
        @(negedge clk);
        check("R9 no restart", busy, 0);
    endtask

    initial begin
        PF[0][0] = 32768; PF[0][1] = 28094; PF[0][2] = 20124;
        PF[1][0] = 38219; PF[1][1] = 32768; PF[1][2] = 23471;
        PF[2][0] = 53357; PF[2][1] = 45747; PF[2][2] = 32768;
        TF[0][0] = 32768; TF[0][1] = 30700; TF[0][2] = 26782;
        TF[1][0] = 34016; TF[1][1] = 32768; TF[1][2] = 28576;
        TF[2][0] = 37068; TF[2][1] = 35695; TF[2][2] = 32768;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R4: large budget, all at full speed stays at full speed
        cur_mode = 8'h00; meas_pwr = {4{16'd1000}}; meas_tpt = {4{16'd2000}};
        budget = 18'h3FFFF;
        t_generic("large budget");
        check("R1 all full speed", mode_out, 8'h00);

        // R2 R3: mixed present modes, moderate budget
        cur_mode = 8'b01_10_01_00;
        meas_pwr = {16'd2200, 16'd800, 16'd1500, 16'd3000};
        meas_tpt = {16'd900, 16'd3000, 16'd1200, 16'd4000};
        budget = 18'd6000;
        t_generic("mixed");

        // R1: code 3 treated as 2
        cur_mode = 8'b11_00_11_01;
        meas_pwr = {16'd1200, 16'd2000, 16'd1700, 16'd2400};
        meas_tpt = {16'd1800, 16'd2200, 16'd600, 16'd2000};
        budget = 18'd5200;
        t_generic("code3");

        t_tie_exact();
        t_nofit();
        t_saturate();
        t_ignore_start();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule